// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one shared synchronisation cell that holds a saturating count. Two request channels reach it in parallel, a read channel and a write channel, and each carries a 3-bit view code that selects how the access is interpreted. Reads through the two semaphore views take a unit from the count and return the count as it stood before the take. Writes through those views give a unit back. The write data of a give is not used.

When the count is zero, a read through the waiting semaphore view does not complete. Instead the requester's identifier is recorded in a parked-requester mask. The next give, through either semaphore view, pulses a wake output that carries the mask of everyone released and then empties the mask. The raw view exposes the count directly. The control view exposes three tag flags that use the same bit layout as a queue cell, and the queue-mode flag in that layout always reads zero. The two queue views answer as if the cell were not a queue. Unused view codes return all ones.

When a take and a give arrive in the same cycle, the give is applied first. Read responses are registered and appear one cycle after the request.

Top module: `sem_cell`

## Requirements
- R1: A read with view 4 (wait) or 5 (try) on a nonzero count gets a response in the following cycle. The response data is the count before it is decremented by one.
- R2: A read with view 5 (try) on a zero count responds with 0 and leaves the count at zero.
- R3: A read with view 4 (wait) on a zero count gives no response. It sets the bit of `rd_id` in `parked_mask`, and previously parked bits stay set.
- R4: A write with view 4 or 5 increments the count by one. At 0xFFFF the count stays at 0xFFFF. The write data has no effect.
- R5: Each write with view 4 or 5 empties `parked_mask`. If the mask was non-empty, `wake_pulse` is high for one cycle and `wake_mask` equals the mask as it was before the write. Otherwise `wake_pulse` stays low.
- R6: A read with view 0 (raw) returns the count. A write with view 0 changes nothing.
- R7: A write with view 1 (control) loads the trigger flag from data bit 16, the full flag from bit 1 and the empty flag from bit 0. A read with view 1 returns those flags at the same positions. All other bits read 0, including bit 17, which is the queue-mode flag.
- R8: A read with view 2 or 3 returns 0. A read with view 6 or 7 returns all ones. A write with view 2, 3, 6 or 7 changes nothing.
- R9: While reset is asserted, the count, the tag flags and `parked_mask` are zero, and `rsp_valid` and `wake_pulse` are low.
- R10: When a semaphore read and a semaphore write occur in the same cycle, the write is applied first. A wait on a zero count is therefore satisfied and returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request |
| rd_view | input | 3 | Read view code |
| rd_id | input | ID_W (2) | Identifier of the reading requester |
| wr_valid | input | 1 | Write request |
| wr_view | input | 3 | Write view code |
| wr_data | input | DATA_W (32) | Write data, used by the control view only |
| rsp_valid | output | 1 | Read response valid, one cycle after the request |
| rsp_rdata | output | DATA_W (32) | Read response data |
| parked_mask | output | NREQ (4) | Requesters waiting on a zero count |
| wake_pulse | output | 1 | One-cycle release of parked requesters |
| wake_mask | output | NREQ (4) | Requesters released by the current pulse |

## Verification
The hardest situation to reach from the ports is a give that lands while several requesters are parked. The bench reaches it with two waiting reads from different identifiers on a drained count, followed by a give through the try view. A second hard case is the saturation ceiling. The bench reaches it by streaming 65535 gives, adds one more, and reads the count back through the raw view. The same-cycle take and give is driven on a zero count, where the order of the two operations decides between parking the requester and returning 1.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

   // View codes carried on rd_view / wr_view
   localparam logic [2:0] VIEW_RAW  = 3'd0;
   localparam logic [2:0] VIEW_CTRL = 3'd1;
   localparam logic [2:0] VIEW_QWT  = 3'd2;
   localparam logic [2:0] VIEW_QTRY = 3'd3;
   localparam logic [2:0] VIEW_SWT  = 3'd4;
   localparam logic [2:0] VIEW_STRY = 3'd5;

   // Control-view word bit positions (shared with queue cells)
   localparam int TAG_BIT_EMPTY = 0;
   localparam int TAG_BIT_FULL  = 1;
   localparam int TAG_BIT_TRIG  = 16;
   localparam int TAG_BIT_QMODE = 17;
   localparam int CTRL_WORD_MIN = 32;

   typedef struct packed {
      logic trig;
      logic full;
      logic empty;
   } tag_t;

   typedef struct packed {
      logic raw;
      logic ctrl;
      logic queue;
      logic sem;
      logic wait_on_zero;
      logic bad;
   } view_dec_t;

endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
   import sem_cell_pkg::*;
(
   input  logic [2:0] view,
   output view_dec_t  dec
);

   always_comb begin
      dec = '0;
      unique case (view)
         VIEW_RAW:             dec.raw = 1'b1;
         VIEW_CTRL:            dec.ctrl = 1'b1;
         VIEW_QWT, VIEW_QTRY:  dec.queue = 1'b1;
         VIEW_SWT: begin
            dec.sem          = 1'b1;
            dec.wait_on_zero = 1'b1;
         end
         VIEW_STRY:            dec.sem = 1'b1;
         default:              dec.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/sem_count_reg.sv
module sem_count_reg #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             give,
   input  logic             take,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] count_pre,
   output logic             granted
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_d;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("sem_count_reg: CNT_W must be at least 1");
      end
   endgenerate

   // Give first, then take
   always_comb begin
      count_pre = count_q;
      if (give && (count_q != CNT_MAX)) begin
         count_pre = count_q + 1'b1;
      end
      granted = take && (count_pre != '0);
      count_d = granted ? (count_pre - 1'b1) : count_pre;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else begin
         count_q <= count_d;
      end
   end

   assign count = count_q;

   assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (give && !take && (count_q == CNT_MAX)) |=> (count_q == CNT_MAX));

   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !give && (count_q == '0)) |=> (count_q == '0));

   assert_take_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !give && (count_q != '0)) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/sem_park_track.sv
module sem_park_track #(
   parameter int NREQ = 4,
   parameter int ID_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            release_all,
   input  logic            park,
   input  logic [ID_W-1:0] park_id,
   output logic [NREQ-1:0] mask,
   output logic            wake_pulse,
   output logic [NREQ-1:0] wake_mask
);

   logic [NREQ-1:0] mask_q;
   logic            wake_q;
   logic [NREQ-1:0] wake_mask_q;

   generate
      if (NREQ < 1) begin : g_bad_nreq
         $error("sem_park_track: NREQ must be at least 1");
      end
      if ((1 << ID_W) < NREQ) begin : g_bad_idw
         $error("sem_park_track: ID_W too narrow for NREQ");
      end
      for (genvar i = 0; i < NREQ; i++) begin : g_bit
         logic hit;
         assign hit = park && (park_id == ID_W'(i));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mask_q[i] <= 1'b0;
            end else begin
               // release applies before a park of the same cycle
               mask_q[i] <= (release_all ? 1'b0 : mask_q[i]) | hit;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wake_q      <= 1'b0;
         wake_mask_q <= '0;
      end else begin
         wake_q      <= release_all && (mask_q != '0);
         wake_mask_q <= release_all ? mask_q : '0;
      end
   end

   assign mask       = mask_q;
   assign wake_pulse = wake_q;
   assign wake_mask  = wake_mask_q;

   assert_park_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (park && !release_all) |=> (mask_q[$past(park_id)] == 1'b1));

   assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (release_all && !park) |=> (mask_q == '0));

   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_q && !release_all) |=> !wake_q);

endmodule

// File: rtl/sem_tag_reg.sv
module sem_tag_reg
   import sem_cell_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  tag_t load_val,
   output tag_t tag
);

   tag_t tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= '0;
      end else if (load) begin
         tag_q <= load_val;
      end
   end

   assign tag = tag_q;

   assert_tag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(tag_q));

endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_cell_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   parameter int NREQ   = 4,
   localparam int ID_W  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [2:0]        rd_view,
   input  logic [ID_W-1:0]   rd_id,
   input  logic              wr_valid,
   input  logic [2:0]        wr_view,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [NREQ-1:0]   parked_mask,
   output logic              wake_pulse,
   output logic [NREQ-1:0]   wake_mask
);

   generate
      if (DATA_W < CTRL_WORD_MIN) begin : g_bad_data
         $error("sem_cell: DATA_W must hold the control word");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("sem_cell: CNT_W must not exceed DATA_W");
      end
   endgenerate

   view_dec_t rd_dec;
   view_dec_t wr_dec;

   sem_view_decode u_rd_dec (.view(rd_view), .dec(rd_dec));
   sem_view_decode u_wr_dec (.view(wr_view), .dec(wr_dec));

   logic             give;
   logic             take;
   logic             granted;
   logic             park;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] count_pre;

   assign give = wr_valid && wr_dec.sem;
   assign take = rd_valid && rd_dec.sem;

   sem_count_reg #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .give      (give),
      .take      (take),
      .count     (count),
      .count_pre (count_pre),
      .granted   (granted)
   );

   assign park = take && rd_dec.wait_on_zero && !granted;

   sem_park_track #(.NREQ(NREQ), .ID_W(ID_W)) u_park (
      .clk         (clk),
      .rst_n       (rst_n),
      .release_all (give),
      .park        (park),
      .park_id     (rd_id),
      .mask        (parked_mask),
      .wake_pulse  (wake_pulse),
      .wake_mask   (wake_mask)
   );

   tag_t tag;
   tag_t tag_load;

   assign tag_load.trig  = wr_data[TAG_BIT_TRIG];
   assign tag_load.full  = wr_data[TAG_BIT_FULL];
   assign tag_load.empty = wr_data[TAG_BIT_EMPTY];

   sem_tag_reg u_tag (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_valid && wr_dec.ctrl),
      .load_val (tag_load),
      .tag      (tag)
   );

   // Read data selection
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] rd_word;

   always_comb begin
      ctrl_word                = '0;
      ctrl_word[TAG_BIT_TRIG]  = tag.trig;
      ctrl_word[TAG_BIT_FULL]  = tag.full;
      ctrl_word[TAG_BIT_EMPTY] = tag.empty;
      ctrl_word[TAG_BIT_QMODE] = 1'b0;
   end

   always_comb begin
      rd_word = '1;
      if (rd_dec.sem || rd_dec.raw) begin
         rd_word = DATA_W'(count_pre);
      end else if (rd_dec.ctrl) begin
         rd_word = ctrl_word;
      end else if (rd_dec.queue) begin
         rd_word = '0;
      end else if (rd_dec.bad) begin
         rd_word = '1;
      end
   end

   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= rd_valid && !park;
         if (rd_valid && !park) begin
            rsp_rdata_q <= rd_word;
         end
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_rdata_q;

   // write views that carry no effect on a semaphore cell
   logic unused_wr;
   assign unused_wr = ^{wr_data, wr_dec.raw, wr_dec.queue, wr_dec.bad,
                        wr_dec.wait_on_zero, count};

   assert_park_no_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      park |=> !rsp_valid_q);

   assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !park) |=> rsp_valid_q);

   assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (give && take) |-> !park);

endmodule

// File: tb/sem_cell_bench.sv
`timescale 1ns/1ps
module sem_cell_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_valid = 1'b0;
   logic [2:0]  rd_view = '0;
   logic [1:0]  rd_id = '0;
   logic        wr_valid = 1'b0;
   logic [2:0]  wr_view = '0;
   logic [31:0] wr_data = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [3:0]  parked_mask;
   logic        wake_pulse;
   logic [3:0]  wake_mask;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sem_cell u_sem_cell (
      .clk(clk), .rst_n(rst_n),
      .rd_valid(rd_valid), .rd_view(rd_view), .rd_id(rd_id),
      .wr_valid(wr_valid), .wr_view(wr_view), .wr_data(wr_data),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .parked_mask(parked_mask), .wake_pulse(wake_pulse), .wake_mask(wake_mask)
   );

   function automatic logic [87:0] mk(input int req, input int rv, input int rview,
      input int rid, input int wv, input int wview, input logic [31:0] wd,
      input int ersp, input logic [31:0] erd, input int emask, input int ewake,
      input int ewmask);
      return {4'(req), 1'(rv), 3'(rview), 2'(rid), 1'(wv), 3'(wview), wd,
              1'(ersp), erd, 4'(emask), 1'(ewake), 4'(ewmask)};
   endfunction

   localparam int NV = 20;
   localparam logic [87:0] VEC [NV] = '{
      mk(2, 1,5,0, 0,0,32'h0,        1,32'h0,        0,0,0),   // R2 try on zero
      mk(3, 1,4,1, 0,0,32'h0,        0,32'h0,        2,0,0),   // R3 park id1
      mk(3, 1,4,3, 0,0,32'h0,        0,32'h0,        10,0,0),  // R3 park id3
      mk(5, 0,0,0, 1,5,32'hDEAD,     0,32'h0,        0,1,10),  // R5 release both
      mk(4, 0,0,0, 1,4,32'h1234,     0,32'h0,        0,0,0),   // R4 give, no wake
      mk(6, 1,0,0, 0,0,32'h0,        1,32'h2,        0,0,0),   // R6 raw read
      mk(6, 0,0,0, 1,0,32'h55,       0,32'h0,        0,0,0),   // R6 raw write
      mk(6, 1,0,0, 0,0,32'h0,        1,32'h2,        0,0,0),   // R6 unchanged
      mk(1, 1,4,2, 0,0,32'h0,        1,32'h2,        0,0,0),   // R1 wait take
      mk(1, 1,5,0, 0,0,32'h0,        1,32'h1,        0,0,0),   // R1 try take
      mk(10,1,4,0, 1,5,32'h0,        1,32'h1,        0,0,0),   // R10 give first
      mk(10,1,0,0, 0,0,32'h0,        1,32'h0,        0,0,0),   // R10 count back 0
      mk(7, 0,0,0, 1,1,32'hFFFFFFFF, 0,32'h0,        0,0,0),   // R7 ctrl write
      mk(7, 1,1,0, 0,0,32'h0,        1,32'h00010003, 0,0,0),   // R7 ctrl read
      mk(8, 1,2,0, 0,0,32'h0,        1,32'h0,        0,0,0),   // R8 queue view
      mk(8, 1,6,0, 0,0,32'h0,        1,32'hFFFFFFFF, 0,0,0),   // R8 bad view
      mk(8, 0,0,0, 1,3,32'h77,       0,32'h0,        0,0,0),   // R8 queue write
      mk(8, 1,0,0, 0,0,32'h0,        1,32'h0,        0,0,0),   // R8 count kept
      mk(8, 1,3,0, 1,7,32'h5,        1,32'h0,        0,0,0),   // R8 bad write
      mk(8, 1,0,0, 0,0,32'h0,        1,32'h0,        0,0,0)    // R8 count kept
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic step(input bit rv, input logic [2:0] rvw, input logic [1:0] rid,
                       input bit wv, input logic [2:0] wvw, input logic [31:0] wd);
      rd_valid = rv; rd_view = rvw; rd_id = rid;
      wr_valid = wv; wr_view = wvw; wr_data = wd;
      @(negedge clk);
      rd_valid = 1'b0;
      wr_valid = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      check("R9 rsp_valid", 32'(rsp_valid), 0);
      check("R9 parked_mask", 32'(parked_mask), 0);
      check("R9 wake_pulse", 32'(wake_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [87:0] v;
         string t;
         v = VEC[i];
         t = $sformatf("R%0d vec%0d", int'(v[87:84]), i);
         step(v[83], v[82:80], v[79:78], v[77], v[76:74], v[73:42]);
         check({t, " rsp_valid"}, 32'(rsp_valid), 32'(v[41]));
         if (v[41]) check({t, " rdata"}, rsp_rdata, v[40:9]);
         check({t, " parked"}, 32'(parked_mask), 32'(v[8:5]));
         check({t, " wake"}, 32'(wake_pulse), 32'(v[4]));
         check({t, " wake_mask"}, 32'(wake_mask), 32'(v[3:0]));
      end

      // R4 saturation: count is 0 here
      for (int k = 0; k < 65535; k++) step(1'b0, 3'd0, 2'd0, 1'b1, 3'd4, 32'(k));
      step(1'b1, 3'd0, 2'd0, 1'b0, 3'd0, 32'h0);
      check("R4 at ceiling", rsp_rdata, 32'hFFFF);
      step(1'b0, 3'd0, 2'd0, 1'b1, 3'd5, 32'h0);
      step(1'b1, 3'd0, 2'd0, 1'b0, 3'd0, 32'h0);
      check("R4 saturated", rsp_rdata, 32'hFFFF);
      step(1'b1, 3'd5, 2'd1, 1'b0, 3'd0, 32'h0);
      check("R1 take at ceiling", rsp_rdata, 32'hFFFF);
      step(1'b1, 3'd0, 2'd0, 1'b0, 3'd0, 32'h0);
      check("R1 after take", rsp_rdata, 32'hFFFE);

      // R9 reset in mid-run clears the count and tag
      step(1'b0, 3'd0, 2'd0, 1'b1, 3'd1, 32'h00010000);
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 rsp_valid in reset", 32'(rsp_valid), 0);
      rst_n = 1'b1;
      step(1'b1, 3'd0, 2'd0, 1'b0, 3'd0, 32'h0);
      check("R9 count cleared", rsp_rdata, 32'h0);
      step(1'b1, 3'd1, 2'd0, 1'b0, 3'd0, 32'h0);
      check("R9 tag cleared", rsp_rdata, 32'h0);
      step(1'b1, 3'd4, 2'd0, 1'b0, 3'd0, 32'h0);
      check("R3 park id0", 32'(parked_mask), 32'h1);
      check("R3 no response", 32'(rsp_valid), 0);

      summary();
   end

endmodule